// File: doc/BRIEF.md
# Programmable Interrupt Request Output Controller

This block turns a set of raw event inputs into one interrupt request pin. Each source has a status bit that latches on the rising edge of its event, a mask bit that lets it reach the pin, and a write-1-to-clear bit. One source is a copy-protection detector. A select field picks whether the pseudo-sync flag, the color-stripe flag, or either of them feeds that source. A software stimulus bit can raise the request with no event at all.

The request is either a timed pulse of 3, 15 or 63 clock periods, or a level that holds until software clears or masks every pending cause. Once a request has been raised, later events do not raise it again until everything pending has been cleared or masked. The pin stage can run as open-drain (the output enable is asserted only while the request is active), active-low, active-high, or fully tri-stated.

Configuration, mask, clear and stimulus writes are plain single-cycle strobes. The status vector is a plain level output. No port carries streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_req_ctl`

## Requirements
- R1: After reset, pin_oe_o is 0, status_o is all zero, every source is masked and the stimulus bit is 0.
- R2: Status bit k (k < NUM_EVT) is evt_i[k] and bit NUM_EVT is the copy-protection source. A bit sets on the rising edge of its qualified event, stays set after the event falls, and sets whether or not the source is masked.
- R3: A 1 in clr_i[k] clears status bit k at the next edge. If a new event arrives in the same cycle, the clear wins for that bit only, and other bits can still set in that cycle.
- R4: The request source is the OR of (status AND mask) and the stimulus bit. A masked status bit never raises the pin, and masking does not erase the status bit.
- R5: Width field 00 gives a pulse of 3 cycles, 01 gives 15 cycles and 10 gives 63 cycles. The pulse starts one cycle after the request source turns active.
- R6: With width field 11, the request holds while any unmasked status bit or the stimulus bit is set. This holds even after the causing event has gone away. The request drops one cycle after the last cause is cleared or masked.
- R7: While the request source stays active, a second unmasked event raises no second pulse, and the status bits of both events stay set.
- R8: Once every pending cause has been cleared or masked, the next event raises a new pulse.
- R9: Writing 1 to the stimulus bit raises the request without any event, and writing 0 removes it.
- R10: The drive-mode field selects the output stage. 00 gives open-drain: pin_oe_o follows the request and pin_o is 0. 01 gives pin_oe_o=1 with pin_o low while active. 10 gives pin_oe_o=1 with pin_o high while active. 11 keeps pin_oe_o=0.
- R11: The copy-protection select field picks the source for bit NUM_EVT. 01 selects pseudo-sync, 10 selects color-stripe, 11 selects either of the two, and 00 selects neither.
- R12: The configuration byte holds the width field in bits [7:6], the copy-protection select in [5:4] and the drive mode in [1:0]. Bits [3:2] are ignored. The reset values are width 00, select 01 and drive mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte: width, copy-protection select, drive mode |
| mask_we | input | 1 | Write strobe for the mask vector |
| mask_wdata | input | NUM_EVT+1 | New mask vector (1 = source enabled) |
| clr_i | input | NUM_EVT+1 | Write-1-to-clear strobes, one per status bit |
| stim_we | input | 1 | Write strobe for the stimulus bit |
| stim_wdata | input | 1 | New stimulus bit value |
| evt_i | input | NUM_EVT | Raw event inputs; bit 0 is lock-lost |
| psync_i | input | 1 | Pseudo-sync detector flag |
| stripe_i | input | 1 | Color-stripe detector flag |
| status_o | output | NUM_EVT+1 | Latched status bits |
| pin_o | output | 1 | Interrupt pin output value |
| pin_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The scoreboard measures every pulse width and checks it against the selected count. A timer that is off by one, or that reloads when a second event lands inside a pending window, shows up as a wrong width or as an unexpected extra pulse. In level mode the bench keeps the pin active long after the event has fallen, then removes the cause once by clearing and once by masking. A design that followed the raw event, or that ignored the mask, would leave the pin in the wrong state. A same-cycle clear and event checks that the clear wins only for its own bit. The bench also walks every drive-mode encoding and every copy-protection select, including the reserved codes, to catch a swapped decode or a reserved code that still drives the pin or latches a detector.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  typedef enum logic [1:0] {
    WIDTH_SHORT = 2'b00,
    WIDTH_MID   = 2'b01,
    WIDTH_LONG  = 2'b10,
    WIDTH_LEVEL = 2'b11
  } req_width_e;

  typedef enum logic [1:0] {
    DRV_OPEN = 2'b00,
    DRV_LOW  = 2'b01,
    DRV_HIGH = 2'b10,
    DRV_OFF  = 2'b11
  } drv_mode_e;

  typedef enum logic [1:0] {
    CPD_NONE   = 2'b00,
    CPD_PSYNC  = 2'b01,
    CPD_STRIPE = 2'b10,
    CPD_ANY    = 2'b11
  } cpd_sel_e;

  // bit positions inside the configuration byte
  localparam int WIDTH_LSB = 6;
  localparam int CPD_LSB   = 4;
  localparam int DRV_LSB   = 0;

  typedef struct packed {
    req_width_e width;
    cpd_sel_e   cpd;
    drv_mode_e  drv;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RESET = '{width: WIDTH_SHORT, cpd: CPD_PSYNC, drv: DRV_OPEN};

endpackage

// File: rtl/irq_cpd_qual.sv
module irq_cpd_qual
  import irq_ctl_pkg::*;
(
  input  cpd_sel_e sel_i,
  input  logic     psync_i,
  input  logic     stripe_i,
  output logic     hit_o
);

  always_comb begin
    case (sel_i)
      CPD_PSYNC:  hit_o = psync_i;
      CPD_STRIPE: hit_o = stripe_i;
      CPD_ANY:    hit_o = psync_i | stripe_i;
      default:    hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);

  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] rise;

  assign rise     = raw_i & ~prev_q;
  assign status_o = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= raw_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        stat_q[g] <= 1'b0;
      else if (clr_i[g]) stat_q[g] <= 1'b0;
      else if (rise[g])  stat_q[g] <= 1'b1;
    end

    // R3: a clear strobe always empties its own bit
    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[g] |=> !stat_q[g]);

    // R2: a fresh edge without a clear is captured
    assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_i[g] && !prev_q[g] && !clr_i[g]) |=> stat_q[g]);

    // R2: a set bit survives until cleared
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[g] && !clr_i[g]) |=> stat_q[g]);
  end

endmodule

// File: rtl/irq_req_timer.sv
module irq_req_timer
  import irq_ctl_pkg::*;
#(
  parameter int DUR_SHORT = 3,
  parameter int DUR_MID   = 15,
  parameter int DUR_LONG  = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend_i,
  input  req_width_e width_i,
  output logic       req_o
);

  localparam int CNT_W = $clog2(DUR_LONG + 1);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;
  logic             start;

  always_comb begin
    case (width_i)
      WIDTH_SHORT: load = CNT_W'(DUR_SHORT);
      WIDTH_MID:   load = CNT_W'(DUR_MID);
      WIDTH_LONG:  load = CNT_W'(DUR_LONG);
      default:     load = '0;
    endcase
  end

  // only an inactive-to-active change of the source starts a pulse
  assign start = pend_i & ~pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_i;
      if (start)             cnt_q <= load;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign req_o = (width_i == WIDTH_LEVEL) ? pend_q : (cnt_q != '0);

  // R7: a running pulse is never reloaded while the source stays pending
  assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: with no source and no pulse running the request stays low
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !pend_i && cnt_q == '0) |=> !req_o);

endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage
  import irq_ctl_pkg::*;
(
  input  drv_mode_e mode_i,
  input  logic      req_i,
  output logic      pin_o,
  output logic      pin_oe_o
);

  always_comb begin
    case (mode_i)
      DRV_OPEN: begin pin_o = 1'b0;    pin_oe_o = req_i; end
      DRV_LOW:  begin pin_o = ~req_i;  pin_oe_o = 1'b1;  end
      DRV_HIGH: begin pin_o = req_i;   pin_oe_o = 1'b1;  end
      default:  begin pin_o = 1'b0;    pin_oe_o = 1'b0;  end
    endcase
  end

endmodule

// File: rtl/irq_req_ctl.sv
module irq_req_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_EVT   = 4,
  parameter int DUR_SHORT = 3,
  parameter int DUR_MID   = 15,
  parameter int DUR_LONG  = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             mask_we,
  input  logic [NUM_EVT:0] mask_wdata,
  input  logic [NUM_EVT:0] clr_i,
  input  logic             stim_we,
  input  logic             stim_wdata,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic             psync_i,
  input  logic             stripe_i,
  output logic [NUM_EVT:0] status_o,
  output logic             pin_o,
  output logic             pin_oe_o
);

  localparam int NSRC   = NUM_EVT + 1;
  localparam int CPD_IX = NUM_EVT;

  irq_cfg_t        cfg_q;
  logic [NSRC-1:0] mask_q;
  logic            stim_q;
  logic            cpd_hit;
  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] stat;
  logic            pend;
  logic            req;
  logic            cfg_unused;

  // bits [3:2] of the configuration byte carry no function
  assign cfg_unused = ^cfg_wdata[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      mask_q <= '0;
      stim_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q.width <= req_width_e'(cfg_wdata[WIDTH_LSB +: 2]);
        cfg_q.cpd   <= cpd_sel_e'(cfg_wdata[CPD_LSB +: 2]);
        cfg_q.drv   <= drv_mode_e'(cfg_wdata[DRV_LSB +: 2]);
      end
      if (mask_we) mask_q <= mask_wdata;
      if (stim_we) stim_q <= stim_wdata;
    end
  end

  irq_cpd_qual u_cpd (
    .sel_i    (cfg_q.cpd),
    .psync_i  (psync_i),
    .stripe_i (stripe_i),
    .hit_o    (cpd_hit)
  );

  assign raw = {cpd_hit, evt_i};

  irq_status_bank #(.NSRC(NSRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_i    (raw),
    .clr_i    (clr_i),
    .status_o (stat)
  );

  assign pend = (|(stat & mask_q)) | stim_q;

  irq_req_timer #(
    .DUR_SHORT (DUR_SHORT),
    .DUR_MID   (DUR_MID),
    .DUR_LONG  (DUR_LONG)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend),
    .width_i (cfg_q.width),
    .req_o   (req)
  );

  irq_pin_stage u_pin (
    .mode_i   (cfg_q.drv),
    .req_i    (req),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  assign status_o = stat;

  // R11: reserved select never sets the copy-protection bit
  assert_cpd_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.cpd == CPD_NONE && !stat[CPD_IX]) |=> !stat[CPD_IX]);

  // R10: open-drain mode never drives a high level
  assert_od_never_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.drv == DRV_OPEN && pin_oe_o) |-> !pin_o);

endmodule

// File: tb/tb_irq_req_ctl.sv
module tb_irq_req_ctl;
  localparam int NUM_EVT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [7:0] cfg_wdata;
  logic mask_we;
  logic [NUM_EVT:0] mask_wdata;
  logic [NUM_EVT:0] clr_i;
  logic stim_we, stim_wdata;
  logic [NUM_EVT-1:0] evt_i;
  logic psync_i, stripe_i;
  logic [NUM_EVT:0] status_o;
  logic pin_o, pin_oe_o;

  always #5 clk = ~clk;

  irq_req_ctl #(.NUM_EVT(NUM_EVT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_i(clr_i),
    .stim_we(stim_we), .stim_wdata(stim_wdata), .evt_i(evt_i),
    .psync_i(psync_i), .stripe_i(stripe_i), .status_o(status_o),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  int pulses = 0;
  int width = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  logic [1:0] mon_mode = 2'b00;
  logic mon_act;
  int exp_w[$];
  string exp_tag[$];

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measure active pulse widths and compare with the queue
  always @(negedge clk) begin
    mon_act = (mon_mode == 2'b10) ? (pin_oe_o && pin_o) : (pin_oe_o && !pin_o);
    if (!rst_n || !mon_en) width = 0;
    else if (mon_act) width++;
    else if (width != 0) begin
      pulses++;
      n_checks++;
      if (exp_w.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected pulse: actual %0d expected none", width);
      end else begin
        int w;
        string t;
        w = exp_w.pop_front();
        t = exp_tag.pop_front();
        if (w != width) begin
          n_fail++;
          $display("FAIL %s pulse width: actual %0d expected %0d", t, width, w);
        end
      end
      width = 0;
    end
  end

  task automatic expect_pulse(int w, string tag);
    exp_w.push_back(w);
    exp_tag.push_back(tag);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(logic [1:0] w, logic [1:0] c, logic [1:0] d);
    cfg_wdata = {w, c, 2'b11, d};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_mask(logic [NUM_EVT:0] v);
    mask_wdata = v; mask_we = 1'b1;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic clear(logic [NUM_EVT:0] v);
    clr_i = v;
    @(negedge clk);
    clr_i = '0;
  endtask

  task automatic stim(logic v);
    stim_wdata = v; stim_we = 1'b1;
    @(negedge clk);
    stim_we = 1'b0;
  endtask

  task automatic kick_evt(int i);
    evt_i[i] = 1'b1;
    @(negedge clk);
    evt_i[i] = 1'b0;
  endtask

  task automatic kick_ps();
    psync_i = 1'b1;
    @(negedge clk);
    psync_i = 1'b0;
  endtask

  task automatic kick_cs();
    stripe_i = 1'b1;
    @(negedge clk);
    stripe_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = '0; mask_we = 0; mask_wdata = '0;
    clr_i = '0; stim_we = 0; stim_wdata = 0; evt_i = '0; psync_i = 0; stripe_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_oe after reset", pin_oe_o, 0);
    check("R1 status after reset", status_o, 0);

    // R12 default select is pseudo-sync; R2 latches while masked
    kick_ps();
    check("R12 default select latches pseudo-sync", status_o, 5'h10);
    cyc(3);
    check("R4 masked status keeps pin off", pin_oe_o, 0);
    clear(5'h10);
    check("R3 clear empties bit", status_o, 0);

    // R12 default width 3 in default open-drain mode (R10)
    mon_mode = 2'b00; mon_en = 1'b1;
    wr_mask(5'h10);
    expect_pulse(3, "R12 default width");
    kick_ps();
    cyc(8);
    check("R12 default pulse seen", exp_w.size(), 0);
    check("R10 open-drain idle released", pin_oe_o, 0);
    clear(5'h10);
    wr_mask(5'h1F);

    // R5 each timed width, drive-high mode
    mon_mode = 2'b10;
    wr_cfg(2'b00, 2'b01, 2'b10);
    check("R10 drive-high idle oe", pin_oe_o, 1);
    check("R10 drive-high idle level", pin_o, 0);
    expect_pulse(3, "R5 width 3");
    kick_evt(0); cyc(8); clear(5'h01);
    wr_cfg(2'b01, 2'b01, 2'b10);
    expect_pulse(15, "R5 width 15");
    kick_evt(1); cyc(20);
    check("R2 status held after event fell", status_o[1], 1);
    clear(5'h02);
    wr_cfg(2'b10, 2'b01, 2'b10);
    expect_pulse(63, "R5 width 63");
    kick_evt(2); cyc(70); clear(5'h04);
    check("R5 all timed pulses seen", exp_w.size(), 0);

    // R7 no retrigger while pending, R8 new pulse after full clear
    wr_cfg(2'b00, 2'b01, 2'b10);
    p0 = pulses;
    expect_pulse(3, "R7 first pulse");
    kick_evt(0); cyc(1); kick_evt(1); cyc(10);
    check("R7 both status bits kept", status_o[1:0], 3);
    clear(5'h01); cyc(10);
    check("R7 single pulse while pending", pulses - p0, 1);
    clear(5'h02); cyc(2);
    expect_pulse(3, "R8 new pulse");
    kick_evt(3); cyc(8); clear(5'h08);
    check("R8 second pulse after clear", pulses - p0, 2);

    // R9 stimulus in timed mode
    expect_pulse(3, "R9 stimulus pulse");
    stim(1'b1); cyc(8); stim(1'b0); cyc(2);
    check("R9 stimulus pulse seen", exp_w.size(), 0);

    // R6 level mode
    mon_en = 1'b0;
    wr_cfg(2'b11, 2'b01, 2'b10);
    kick_evt(0); cyc(1);
    check("R6 level asserted", pin_o, 1);
    cyc(40);
    check("R6 level held after event gone", pin_o, 1);
    clear(5'h01); cyc(1);
    check("R6 level dropped by clear", pin_o, 0);
    kick_evt(1); cyc(3);
    check("R6 level asserted again", pin_o, 1);
    wr_mask(5'h1D); cyc(1);
    check("R6 level dropped by mask", pin_o, 0);
    check("R4 masking keeps status", status_o[1], 1);
    clear(5'h02); wr_mask(5'h1F); cyc(2);
    check("R6 stays low after clear", pin_o, 0);

    // R9 stimulus in level mode
    stim(1'b1); cyc(1);
    check("R9 stimulus raises level", pin_o, 1);
    stim(1'b0); cyc(1);
    check("R9 stimulus removed", pin_o, 0);

    // R10 drive modes
    wr_cfg(2'b11, 2'b01, 2'b01);
    check("R10 active-low idle oe", pin_oe_o, 1);
    check("R10 active-low idle high", pin_o, 1);
    stim(1'b1); cyc(1);
    check("R10 active-low asserted", pin_o, 0);
    wr_cfg(2'b11, 2'b01, 2'b00);
    check("R10 open-drain active oe", pin_oe_o, 1);
    check("R10 open-drain active low", pin_o, 0);
    stim(1'b0); cyc(1);
    check("R10 open-drain released", pin_oe_o, 0);
    wr_cfg(2'b11, 2'b01, 2'b11);
    stim(1'b1); cyc(1);
    check("R10 reserved mode tri-state", pin_oe_o, 0);
    stim(1'b0); cyc(1);

    // R11 copy-protection select
    kick_cs();
    check("R11 psync select ignores stripe", status_o[4], 0);
    kick_ps();
    check("R11 psync select takes psync", status_o[4], 1);
    clear(5'h10);
    wr_cfg(2'b11, 2'b10, 2'b11);
    kick_ps();
    check("R11 stripe select ignores psync", status_o[4], 0);
    kick_cs();
    check("R11 stripe select takes stripe", status_o[4], 1);
    clear(5'h10);
    wr_cfg(2'b11, 2'b11, 2'b11);
    kick_ps();
    check("R11 either select takes psync", status_o[4], 1);
    clear(5'h10);
    kick_cs();
    check("R11 either select takes stripe", status_o[4], 1);
    clear(5'h10);
    wr_cfg(2'b11, 2'b00, 2'b11);
    kick_ps(); kick_cs();
    check("R11 reserved select sets nothing", status_o[4], 0);

    // R3 clear wins for its own bit only
    evt_i[0] = 1'b1; evt_i[1] = 1'b1; clr_i = 5'h01;
    @(negedge clk);
    evt_i = '0; clr_i = '0;
    check("R3 clear priority per bit", status_o[1:0], 2);
    clear(5'h02);
    check("R3 final clear", status_o, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule